// File: doc/BRIEF.md
# Accelerator control register slave

This block sits between a host bus and a one-shot compute core. Software programs the core's argument words, launches the core by setting a launch bit, and learns about completion by polling a completion flag or by taking an interrupt. The core sees a launch level, the argument values, and a result input. It answers with completion, idle and ready indications. The bus is a simple single-cycle port. A write takes effect at the clock edge where `bus_wr` is high. A read captures its data at the clock edge where `bus_rd` is high.

The launch bit is held by a two-state machine. In LS_STOPPED the launch output is low. The transition *sw_launch* (a control write with bit 0 set) moves it to LS_ARMED, where the launch output is high. From LS_ARMED, the transition *handshake_stop* (core ready while re-arm is off) returns it to LS_STOPPED. The transition *handshake_rearm* (core ready while re-arm is on) keeps it in LS_ARMED. The completion flag is a second two-state machine. DN_CLEAR moves to DN_PENDING on *core_finish* (a completion pulse). DN_PENDING moves back to DN_CLEAR on *status_read* (a bus read of the control word in a cycle without a completion pulse).

Interrupts have two channels: channel 0 is completion and channel 1 is ready. Each channel has an enable bit and a status bit, and one master enable gates the output line.

Top module: `kernel_ctl_slave`

## Requirements
- R1: After reset, the launch output, the interrupt line, the read data, all argument outputs and every register read back as zero.
- R2: A write to byte address 0x00 with bit 0 set raises `core_start` in the next cycle. A write there with bit 0 clear leaves `core_start` unchanged.
- R3: While `core_start` is high and the re-arm bit is clear, a cycle with `core_ready` high drops `core_start` in the next cycle.
- R4: Bit 7 of address 0x00 is a read/write re-arm bit. Every write to 0x00 loads it. While it is set, `core_start` stays high through a `core_ready` handshake.
- R5: A `core_done` pulse sets the completion flag, which reads as bit 1 of address 0x00. The first read of 0x00 returns the flag as 1 and then clears it. If a read and a completion pulse fall in the same cycle, the flag stays set.
- R6: Address 0x00 reads as launch in bit 0, completion in bit 1, live `core_idle` in bit 2, live `core_ready` in bit 3 and re-arm in bit 7. All other bits read as zero, and writes to bits 1 to 6 have no effect.
- R7: Bit 0 of address 0x04 is the master interrupt enable. Bits 1:0 of address 0x08 are the channel enables. Both are read/write, and their other bits read as zero.
- R8: Status bit 0 at address 0x0C sets on a `core_done` pulse and status bit 1 sets on a `core_ready` pulse. A status bit sets only when its channel enable is set.
- R9: Writing a 1 to a status bit inverts it, and writing a 0 leaves it unchanged. A core event in the same cycle as an inverting write leaves the bit set.
- R10: `irq` is high exactly when the master enable is set and at least one status bit is set.
- R11: Argument k (k = 0..4) is read/write at 0x10, 0x18, 0x20, 0x28 and 0x38 respectively, and drives `core_args[32k+31:32k]`.
- R12: Address 0x30 returns the `core_result` value captured on the most recent `core_done` pulse. Writes to 0x30 are ignored.
- R13: The reserved words 0x14, 0x1C, 0x24, 0x2C, 0x34 and 0x3C read as zero. Writes to them change no output and no register.
- R14: `bus_rdata` changes only at a clock edge where `bus_rd` is high, and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| core_start | output | 1 | Launch level to the core |
| core_args | output | NUM_ARGS*DATA_W | Argument values, argument k in slice k |
| core_done | input | 1 | Completion pulse from the core |
| core_idle | input | 1 | Core idle level |
| core_ready | input | 1 | Core accepts the launch (handshake) |
| core_result | input | DATA_W | Result value, valid with `core_done` |
| irq | output | 1 | Interrupt line |

## Verification
The bench builds the block with its defaults: 32-bit words, five arguments, the result in slot 4 and a 6-bit address. These values place the result word between argument 3 and argument 4, so the skipped slot in the argument mapping is exercised. They also make the highest reserved word 0x3C the last address in the window, so the bench can reach the upper edge of the map. Random argument writes, reserved-word writes and status inversions are compared against a model in the bench. Directed cases cover handshakes with and without re-arm, a read that coincides with completion, and an inverting write that coincides with an event.

// File: rtl/kcs_pkg.sv
package kcs_pkg;

    typedef enum logic {
        LS_STOPPED = 1'b0,
        LS_ARMED   = 1'b1
    } launch_state_e;

    typedef enum logic {
        DN_CLEAR   = 1'b0,
        DN_PENDING = 1'b1
    } done_state_e;

    // byte offsets of the fixed words
    localparam int unsigned OFF_CTRL      = 0;
    localparam int unsigned OFF_GIE       = 4;
    localparam int unsigned OFF_IER       = 8;
    localparam int unsigned OFF_ISR       = 12;
    localparam int unsigned OFF_SLOT_BASE = 16;
    localparam int unsigned SLOT_STRIDE   = 8;

    // control word bit positions
    localparam int unsigned BIT_START = 0;
    localparam int unsigned BIT_DONE  = 1;
    localparam int unsigned BIT_IDLE  = 2;
    localparam int unsigned BIT_READY = 3;
    localparam int unsigned BIT_AUTO  = 7;

    // interrupt channels
    localparam int unsigned CH_DONE  = 0;
    localparam int unsigned CH_READY = 1;
    localparam int unsigned NUM_CH   = 2;

    // argument k skips over the result slot
    function automatic int unsigned arg_slot(int unsigned k, int unsigned result_slot);
        return (k < result_slot) ? k : k + 1;
    endfunction

endpackage

// File: rtl/kcs_launch_fsm.sv
module kcs_launch_fsm
    import kcs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ctrl_wr,
    input  logic wr_start,
    input  logic wr_auto,
    input  logic ctrl_rd,
    input  logic core_done,
    input  logic core_ready,
    output logic core_start,
    output logic done_flag,
    output logic auto_restart
);

    launch_state_e ls_q, ls_d;
    done_state_e   ds_q, ds_d;
    logic          auto_q;

    // state registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ls_q   <= LS_STOPPED;
            ds_q   <= DN_CLEAR;
            auto_q <= 1'b0;
        end else begin
            ls_q <= ls_d;
            ds_q <= ds_d;
            if (ctrl_wr) begin
                auto_q <= wr_auto;
            end
        end
    end

    // launch transitions
    always_comb begin
        ls_d = ls_q;
        unique case (ls_q)
            LS_STOPPED: begin
                if (ctrl_wr && wr_start) begin
                    ls_d = LS_ARMED;                 // sw_launch
                end
            end
            LS_ARMED: begin
                if (ctrl_wr && wr_start) begin
                    ls_d = LS_ARMED;                 // sw_launch keeps it armed
                end else if (core_ready && !auto_q) begin
                    ls_d = LS_STOPPED;               // handshake_stop
                end else begin
                    ls_d = LS_ARMED;                 // handshake_rearm or waiting
                end
            end
            default: ls_d = LS_STOPPED;
        endcase
    end

    // completion flag transitions
    always_comb begin
        ds_d = ds_q;
        unique case (ds_q)
            DN_CLEAR: begin
                if (core_done) begin
                    ds_d = DN_PENDING;               // core_finish
                end
            end
            DN_PENDING: begin
                if (ctrl_rd && !core_done) begin
                    ds_d = DN_CLEAR;                 // status_read
                end
            end
            default: ds_d = DN_CLEAR;
        endcase
    end

    // outputs
    always_comb begin
        core_start   = (ls_q == LS_ARMED);
        done_flag    = (ds_q == DN_PENDING);
        auto_restart = auto_q;
    end

endmodule

// File: rtl/kcs_irq.sv
module kcs_irq
    import kcs_pkg::*;
#(
    parameter int unsigned NCH = NUM_CH
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           gie_wr,
    input  logic           gie_bit,
    input  logic           ier_wr,
    input  logic [NCH-1:0] ier_bits,
    input  logic           isr_wr,
    input  logic [NCH-1:0] isr_bits,
    input  logic [NCH-1:0] evt,
    output logic           gie,
    output logic [NCH-1:0] ier,
    output logic [NCH-1:0] isr,
    output logic           irq
);

    logic           gie_q;
    logic [NCH-1:0] ier_q;
    logic [NCH-1:0] isr_q;
    logic [NCH-1:0] isr_d;

    // invert on written ones, then let enabled events set
    always_comb begin
        for (int ch = 0; ch < int'(NCH); ch++) begin
            isr_d[ch] = (isr_q[ch] ^ (isr_wr & isr_bits[ch])) | (evt[ch] & ier_q[ch]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gie_q <= 1'b0;
            ier_q <= '0;
            isr_q <= '0;
        end else begin
            if (gie_wr) begin
                gie_q <= gie_bit;
            end
            if (ier_wr) begin
                ier_q <= ier_bits;
            end
            isr_q <= isr_d;
        end
    end

    assign gie = gie_q;
    assign ier = ier_q;
    assign isr = isr_q;
    assign irq = gie_q & (|isr_q);

endmodule

// File: rtl/kcs_argbank.sv
module kcs_argbank
    import kcs_pkg::*;
#(
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned NUM_ARGS    = 5,
    parameter int unsigned ADDR_W      = 6,
    parameter int unsigned RESULT_SLOT = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bus_wr,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic [DATA_W-1:0]          bus_wdata,
    input  logic                       core_done,
    input  logic [DATA_W-1:0]          core_result,
    output logic [NUM_ARGS*DATA_W-1:0] args_flat,
    output logic [DATA_W-1:0]          result_q,
    output logic [DATA_W-1:0]          rd_val
);

    localparam logic [ADDR_W-1:0] RESULT_ADDR =
        ADDR_W'(OFF_SLOT_BASE + SLOT_STRIDE * RESULT_SLOT);

    logic [NUM_ARGS-1:0] sel;

    for (genvar k = 0; k < int'(NUM_ARGS); k++) begin : g_arg
        localparam logic [ADDR_W-1:0] SLOT_ADDR =
            ADDR_W'(OFF_SLOT_BASE + SLOT_STRIDE * arg_slot(k, RESULT_SLOT));
        logic [DATA_W-1:0] val_q;

        assign sel[k] = (bus_addr == SLOT_ADDR);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                val_q <= '0;
            end else if (bus_wr && sel[k]) begin
                val_q <= bus_wdata;
            end
        end

        assign args_flat[k*DATA_W +: DATA_W] = val_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result_q <= '0;
        end else if (core_done) begin
            result_q <= core_result;
        end
    end

    always_comb begin
        rd_val = '0;
        for (int k = 0; k < int'(NUM_ARGS); k++) begin
            if (sel[k]) begin
                rd_val = args_flat[k*DATA_W +: DATA_W];
            end
        end
        if (bus_addr == RESULT_ADDR) begin
            rd_val = result_q;
        end
    end

endmodule

// File: rtl/kernel_ctl_slave.sv
module kernel_ctl_slave
    import kcs_pkg::*;
#(
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned NUM_ARGS    = 5,
    parameter int unsigned RESULT_SLOT = 4,
    parameter int unsigned ADDR_W      = 6
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bus_wr,
    input  logic                       bus_rd,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic [DATA_W-1:0]          bus_wdata,
    output logic [DATA_W-1:0]          bus_rdata,
    output logic                       core_start,
    output logic [NUM_ARGS*DATA_W-1:0] core_args,
    input  logic                       core_done,
    input  logic                       core_idle,
    input  logic                       core_ready,
    input  logic [DATA_W-1:0]          core_result,
    output logic                       irq
);

    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFF_CTRL);
    localparam logic [ADDR_W-1:0] A_GIE  = ADDR_W'(OFF_GIE);
    localparam logic [ADDR_W-1:0] A_IER  = ADDR_W'(OFF_IER);
    localparam logic [ADDR_W-1:0] A_ISR  = ADDR_W'(OFF_ISR);

    logic hit_ctrl, hit_gie, hit_ier, hit_isr;
    logic done_flag, auto_restart;
    logic gie;
    logic [NUM_CH-1:0] ier, isr, evt;
    logic [DATA_W-1:0] result_q, arg_rd, rd_d;

    assign hit_ctrl = (bus_addr == A_CTRL);
    assign hit_gie  = (bus_addr == A_GIE);
    assign hit_ier  = (bus_addr == A_IER);
    assign hit_isr  = (bus_addr == A_ISR);

    assign evt[CH_DONE]  = core_done;
    assign evt[CH_READY] = core_ready;

    kcs_launch_fsm u_launch (
        .clk          (clk),
        .rst_n        (rst_n),
        .ctrl_wr      (bus_wr & hit_ctrl),
        .wr_start     (bus_wdata[BIT_START]),
        .wr_auto      (bus_wdata[BIT_AUTO]),
        .ctrl_rd      (bus_rd & hit_ctrl),
        .core_done    (core_done),
        .core_ready   (core_ready),
        .core_start   (core_start),
        .done_flag    (done_flag),
        .auto_restart (auto_restart)
    );

    kcs_irq #(.NCH(NUM_CH)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .gie_wr   (bus_wr & hit_gie),
        .gie_bit  (bus_wdata[0]),
        .ier_wr   (bus_wr & hit_ier),
        .ier_bits (bus_wdata[NUM_CH-1:0]),
        .isr_wr   (bus_wr & hit_isr),
        .isr_bits (bus_wdata[NUM_CH-1:0]),
        .evt      (evt),
        .gie      (gie),
        .ier      (ier),
        .isr      (isr),
        .irq      (irq)
    );

    kcs_argbank #(
        .DATA_W      (DATA_W),
        .NUM_ARGS    (NUM_ARGS),
        .ADDR_W      (ADDR_W),
        .RESULT_SLOT (RESULT_SLOT)
    ) u_args (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_wr      (bus_wr),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .core_done   (core_done),
        .core_result (core_result),
        .args_flat   (core_args),
        .result_q    (result_q),
        .rd_val      (arg_rd)
    );

    // read mux
    always_comb begin
        rd_d = '0;
        if (hit_ctrl) begin
            rd_d[BIT_START] = core_start;
            rd_d[BIT_DONE]  = done_flag;
            rd_d[BIT_IDLE]  = core_idle;
            rd_d[BIT_READY] = core_ready;
            rd_d[BIT_AUTO]  = auto_restart;
        end else if (hit_gie) begin
            rd_d[0] = gie;
        end else if (hit_ier) begin
            rd_d[NUM_CH-1:0] = ier;
        end else if (hit_isr) begin
            rd_d[NUM_CH-1:0] = isr;
        end else begin
            rd_d = arg_rd;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            bus_rdata <= rd_d;
        end
    end

endmodule

// File: rtl/kcs_checker.sv
module kcs_checker #(
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [1:0]        wd_lo,
    input logic              core_start,
    input logic              core_done,
    input logic              core_ready,
    input logic              irq,
    input logic              auto_restart,
    input logic              done_flag,
    input logic              gie,
    input logic [1:0]        ier,
    input logic [1:0]        isr,
    input logic [DATA_W-1:0] result_q
);

    localparam logic [ADDR_W-1:0] C_CTRL = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] C_ISR  = ADDR_W'(12);

    a_r2_start_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_start) |-> $past(bus_wr && bus_addr == C_CTRL && wd_lo[0]));

    a_r3_handshake_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (core_start && core_ready && !auto_restart && !(bus_wr && bus_addr == C_CTRL && wd_lo[0]))
        |=> !core_start);

    a_r4_rearm_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (core_start && core_ready && auto_restart) |=> core_start);

    a_r5_done_sets: assert property (@(posedge clk) disable iff (!rst_n)
        core_done |=> done_flag);

    a_r5_done_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (done_flag && bus_rd && bus_addr == C_CTRL && !core_done) |=> !done_flag);

    a_r8_isr0_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(isr[0]) |-> $past((core_done && ier[0]) || (bus_wr && bus_addr == C_ISR && wd_lo[0])));

    a_r8_isr1_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(isr[1]) |-> $past((core_ready && ier[1]) || (bus_wr && bus_addr == C_ISR && wd_lo[1])));

    a_r10_irq_needs_gie: assert property (@(posedge clk) disable iff (!rst_n)
        !gie |-> !irq);

    a_r10_irq_needs_status: assert property (@(posedge clk) disable iff (!rst_n)
        (isr == 2'b00) |-> !irq);

    a_r12_result_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !core_done |=> $stable(result_q));

endmodule

bind kernel_ctl_slave kcs_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_wr       (bus_wr),
    .bus_rd       (bus_rd),
    .bus_addr     (bus_addr),
    .wd_lo        (bus_wdata[1:0]),
    .core_start   (core_start),
    .core_done    (core_done),
    .core_ready   (core_ready),
    .irq          (irq),
    .auto_restart (auto_restart),
    .done_flag    (done_flag),
    .gie          (gie),
    .ier          (ier),
    .isr          (isr),
    .result_q     (result_q)
);

// File: tb/test_kernel_ctl_slave.sv
`timescale 1ns/1ps
module test_kernel_ctl_slave;

    localparam int DW = 32;
    localparam int NA = 5;
    localparam int AW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0, bus_rd = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          core_start;
    logic [NA*DW-1:0] core_args;
    logic          core_done = 1'b0, core_idle = 1'b0, core_ready = 1'b0;
    logic [DW-1:0] core_result = '0;
    logic          irq;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    kernel_ctl_slave i_kernel_ctl_slave (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .core_start(core_start), .core_args(core_args), .core_done(core_done),
        .core_idle(core_idle), .core_ready(core_ready), .core_result(core_result),
        .irq(irq)
    );

    // ---- bench functions from the requirements ----
    function automatic logic [AW-1:0] slot_addr(int k);
        int s = (k < 4) ? k : k + 1;
        return AW'(16 + 8 * s);
    endfunction

    function automatic logic [DW-1:0] exp_ctrl(bit st, bit dn, bit idl, bit rdy, bit au);
        logic [DW-1:0] v = '0;
        v[0] = st; v[1] = dn; v[2] = idl; v[3] = rdy; v[7] = au;
        return v;
    endfunction

    task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [AW-1:0] a, output logic [DW-1:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic pulse_done(logic [DW-1:0] r);
        @(negedge clk);
        core_done = 1'b1; core_result = r;
        @(negedge clk);
        core_done = 1'b0;
    endtask

    task automatic pulse_ready();
        @(negedge clk);
        core_ready = 1'b1;
        @(negedge clk);
        core_ready = 1'b0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            summary();
        end
    end

    initial begin
        logic [DW-1:0] d;
        logic [DW-1:0] m_arg [NA];
        logic [1:0]    exp_isr;
        int unsigned   seed_init;

        seed_init = $urandom(32'd7715);
        for (int k = 0; k < NA; k++) m_arg[k] = '0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 start", {31'b0, core_start}, 0);
        chk("R1 irq", {31'b0, irq}, 0);
        chk("R1 rdata", bus_rdata, 0);
        chk("R1 args", core_args[DW-1:0] | core_args[NA*DW-1 -: DW], 0);
        rd(AW'(4), d);  chk("R1 gie", d, 0);
        rd(AW'(12), d); chk("R1 isr", d, 0);

        // R6 live idle and ready bits, writes to bits 1..6 ignored
        core_idle = 1'b1;
        rd(AW'(0), d); chk("R6 idle", d, exp_ctrl(0,0,1,0,0));
        core_idle = 1'b0; core_ready = 1'b1;
        rd(AW'(0), d); chk("R6 ready", d, exp_ctrl(0,0,0,1,0));
        core_ready = 1'b0;
        wr(AW'(0), 32'hFFFF_FF7E);
        rd(AW'(0), d); chk("R6 ignored bits", d, exp_ctrl(0,0,0,0,0));

        // R2 launch
        wr(AW'(0), 0);
        chk("R2 zero write", {31'b0, core_start}, 0);
        wr(AW'(0), 1);
        chk("R2 launch", {31'b0, core_start}, 1);
        rd(AW'(0), d); chk("R2 readback", d, exp_ctrl(1,0,0,0,0));
        wr(AW'(0), 0);
        chk("R2 clear write no effect", {31'b0, core_start}, 1);

        // R3 handshake stop
        pulse_ready();
        chk("R3 handshake", {31'b0, core_start}, 0);
        rd(AW'(0), d); chk("R3 readback", d, 0);

        // R4 re-arm
        wr(AW'(0), 32'h81);
        rd(AW'(0), d); chk("R4 readback", d, exp_ctrl(1,0,0,0,1));
        pulse_ready();
        chk("R4 stays armed", {31'b0, core_start}, 1);
        wr(AW'(0), 0);
        rd(AW'(0), d); chk("R4 cleared", d, exp_ctrl(1,0,0,0,0));
        pulse_ready();
        chk("R4 stop after clear", {31'b0, core_start}, 0);

        // R5 completion flag, R12 result capture
        pulse_done(32'hCAFE_0001);
        rd(AW'(0), d); chk("R5 done set", d, exp_ctrl(0,1,0,0,0));
        rd(AW'(0), d); chk("R5 clear on read", d, 0);
        rd(AW'(48), d); chk("R12 result", d, 32'hCAFE_0001);
        wr(AW'(48), 32'h1234_5678);
        rd(AW'(48), d); chk("R12 write ignored", d, 32'hCAFE_0001);

        // R5 read coinciding with completion
        pulse_done(32'hCAFE_0002);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = AW'(0); core_done = 1'b1; core_result = 32'hCAFE_0003;
        @(negedge clk);
        bus_rd = 1'b0; core_done = 1'b0;
        chk("R5 collide read", bus_rdata, exp_ctrl(0,1,0,0,0));
        rd(AW'(0), d); chk("R5 set wins", d, exp_ctrl(0,1,0,0,0));
        rd(AW'(0), d); chk("R5 cleared after", d, 0);
        rd(AW'(48), d); chk("R12 latest result", d, 32'hCAFE_0003);

        // R7 enables
        wr(AW'(4), 32'hFFFF_FFFF);
        rd(AW'(4), d); chk("R7 gie", d, 1);
        wr(AW'(8), 32'hFFFF_FFFF);
        rd(AW'(8), d); chk("R7 ier", d, 3);
        wr(AW'(4), 0);
        wr(AW'(8), 0);

        // R8 gating by channel enable
        pulse_done(32'h1);
        rd(AW'(12), d); chk("R8 disabled done", d, 0);
        rd(AW'(0), d);
        wr(AW'(8), 1);
        pulse_ready();
        rd(AW'(12), d); chk("R8 disabled ready", d, 0);
        pulse_done(32'h2);
        rd(AW'(12), d); chk("R8 done status", d, 1);
        chk("R10 no gie", {31'b0, irq}, 0);
        rd(AW'(0), d);
        wr(AW'(4), 1);
        chk("R10 gie on", {31'b0, irq}, 1);
        wr(AW'(8), 3);
        pulse_ready();
        rd(AW'(12), d); chk("R8 ready status", d, 3);

        // R9 inversion
        wr(AW'(12), 1);
        rd(AW'(12), d); chk("R9 invert 0", d, 2);
        chk("R10 one pending", {31'b0, irq}, 1);
        wr(AW'(12), 2);
        rd(AW'(12), d); chk("R9 invert 1", d, 0);
        chk("R10 none pending", {31'b0, irq}, 0);
        wr(AW'(12), 1);
        rd(AW'(12), d); chk("R9 invert sets", d, 1);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = AW'(12); bus_wdata = 1; core_done = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; core_done = 1'b0;
        rd(AW'(12), d); chk("R9 event wins", d, 1);
        rd(AW'(0), d);
        wr(AW'(12), 1);
        wr(AW'(8), 0);
        exp_isr = 2'b00;

        // R14 read data holds between reads
        wr(slot_addr(0), 32'hAAAA_0000);
        m_arg[0] = 32'hAAAA_0000;
        rd(slot_addr(0), d);
        wr(slot_addr(0), 32'hBBBB_0000);
        m_arg[0] = 32'hBBBB_0000;
        chk("R14 hold", bus_rdata, 32'hAAAA_0000);

        // R11 R13 R9 R10 random mix
        for (int it = 0; it < 300; it++) begin
            int unsigned op = $urandom % 4;
            int k = int'($urandom % NA);
            logic [DW-1:0] v = $urandom;
            logic [NA*DW-1:0] flat;
            if (op == 0) begin
                wr(slot_addr(k), v);
                m_arg[k] = v;
            end else if (op == 1) begin
                rd(slot_addr(k), d);
                chk("R11 arg read", d, m_arg[k]);
            end else if (op == 2) begin
                logic [AW-1:0] ra = AW'(20 + 8 * ($urandom % 6));
                wr(ra, v);
                rd(ra, d);
                chk("R13 reserved", d, 0);
            end else begin
                logic [1:0] m = 2'(v);
                wr(AW'(12), {30'b0, m});
                exp_isr = exp_isr ^ m;
                rd(AW'(12), d);
                chk("R9 random invert", d, {30'b0, exp_isr});
                chk("R10 random irq", {31'b0, irq}, {31'b0, |exp_isr});
            end
            for (int j = 0; j < NA; j++) flat[j*DW +: DW] = m_arg[j];
            chk("R11 arg outputs", (core_args == flat) ? 1 : 0, 1);
        end

        finished = 1'b1;
        summary();
    end

endmodule